// File: doc/BRIEF.md
# Paravirtual Device Register Front-End

This block is the register face of a legacy-style paravirtual I/O device that sits behind one memory window. A host issues single-beat register accesses, each carrying an address, a byte size, a direction and write data. The block decodes the offset and the size and holds the feature words, the queue address, the queue selector, the last notified queue and the device status. It looks up the size of the selected queue from the back end. Accesses at or above a fixed boundary are handed to a device-specific configuration port, rebased to zero.

The block also owns the device's single interrupt line. A one-cycle kick from the back end sets a pending flag, and the flag drives the line. Reading the interrupt-status byte returns the flag and clears it.

Flow rules: the block accepts a request in every cycle that `req_valid` is high and never applies back-pressure. Each accepted request produces exactly one response beat (`rsp_valid`) in the following cycle. The response has no ready signal, so the requester must take every beat. The configuration port is a combinational pass-through, and `cfg_rdata` must be valid in the same cycle as `cfg_valid`. Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. Code 3 is always an error.

Top module: `pvdev_regfront`

## Requirements
- R1: Offset 0x00 (4 bytes) reads the `host_features` input. A correctly sized write there changes nothing, raises `warn` for one cycle and gives no error.
- R2: Offset 0x04 (guest features) and offset 0x08 (queue address) are 4-byte read/write registers. Their values drive `guest_features` and `queue_addr`.
- R3: Offset 0x0E is a 2-byte read/write queue selector that drives `qsz_sel`. A 2-byte read of offset 0x0C returns `qsz_value`. Any write to 0x0C is an access error.
- R4: A 2-byte write to offset 0x10 stores the value. One cycle later it pulses `notify_valid` for exactly one cycle, with `notify_idx` equal to the written value. A read of 0x10 returns the stored value.
- R5: Offset 0x12 is a 1-byte read/write device status that drives `dev_status`.
- R6: A 1-byte read of offset 0x13 returns 1 if an interrupt is pending and 0 if not, and clears the pending flag so that `irq` falls. A write to 0x13 is ignored, raises `warn` and leaves `irq` unchanged.
- R7: A `kick` pulse raises `irq` in the next cycle. If a kick and an interrupt-status read fall in the same cycle, the read returns the old flag and `irq` stays high.
- R8: Any access with address at or above 0x14 (parameter `CFG_BASE`) drives `cfg_valid` in the same cycle, with `cfg_addr` equal to the address minus 0x14. It passes the size, direction and write data through and returns `cfg_rdata`. No core register changes.
- R9: A size that differs from the register's width, size code 3, or an unmapped offset below 0x14 yields `rsp_err` = 1 and `rsp_rdata` = 0, and the access has no effect.
- R10: Writing 0 to device status clears guest features, the queue selector, the stored notify value and the pending flag. The queue address is kept. A kick in the same cycle still sets the flag.
- R11: After reset all registers are zero, and `irq`, `rsp_valid`, `notify_valid` and `warn` are low. Each request gives one response beat in the next cycle, and write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response beat, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero-extended |
| rsp_err | output | 1 | Access error for this response |
| cfg_valid | output | 1 | Configuration-space access this cycle |
| cfg_write | output | 1 | Direction of the configuration access |
| cfg_addr | output | ADDR_W | Rebased configuration offset |
| cfg_size | output | 2 | Size code passed through |
| cfg_wdata | output | 32 | Write data passed through |
| cfg_rdata | input | 32 | Configuration read data, same cycle |
| qsz_sel | output | 16 | Currently selected queue |
| qsz_value | input | 16 | Size of the selected queue |
| host_features | input | 32 | Feature word offered by the device |
| kick | input | 1 | Back-end interrupt request pulse |
| irq | output | 1 | Interrupt line (pending flag) |
| notify_valid | output | 1 | One-cycle queue notification strobe |
| notify_idx | output | 16 | Notified queue index |
| guest_features | output | 32 | Features accepted by the driver |
| queue_addr | output | 32 | Queue address of the selected queue |
| dev_status | output | 8 | Device status byte |
| warn | output | 1 | One-cycle pulse on an ignored write |

## Verification
The bench builds the block with its default parameters: an 8-bit address and a configuration boundary at 0x14. With these values the full window is reachable, from the lowest core register through the boundary itself to the top offset 0xFF. The bench can therefore check that the rebase yields exactly 0 at the boundary and larger offsets above it. The 16-bit queue selector feeds a bench model in which each queue's size is derived from its index, so any change of selector shows up directly in the queue-size read.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;
  typedef enum logic [1:0] {
    SZ_1   = 2'd0,
    SZ_2   = 2'd1,
    SZ_4   = 2'd2,
    SZ_BAD = 2'd3
  } size_e;

  typedef enum logic [3:0] {
    RG_HOSTF,
    RG_GUESTF,
    RG_QADDR,
    RG_QSIZE,
    RG_QSEL,
    RG_QNOTIFY,
    RG_STATUS,
    RG_ISR,
    RG_CFG,
    RG_NONE
  } reg_e;

  localparam int OFS_HOSTF   = 'h00;
  localparam int OFS_GUESTF  = 'h04;
  localparam int OFS_QADDR   = 'h08;
  localparam int OFS_QSIZE   = 'h0C;
  localparam int OFS_QSEL    = 'h0E;
  localparam int OFS_QNOTIFY = 'h10;
  localparam int OFS_STATUS  = 'h12;
  localparam int OFS_ISR     = 'h13;
endpackage

// File: rtl/pvdev_decode.sv
module pvdev_decode
  import pvdev_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CFG_BASE = 'h14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  output reg_e              sel,
  output logic              is_cfg,
  output logic              err
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);

  size_e need;

  always_comb begin
    is_cfg = (addr >= BASE_A);
    sel    = RG_NONE;
    need   = SZ_4;
    if (is_cfg) begin
      sel = RG_CFG;
    end else if (addr == ADDR_W'(OFS_HOSTF)) begin
      sel = RG_HOSTF;
    end else if (addr == ADDR_W'(OFS_GUESTF)) begin
      sel = RG_GUESTF;
    end else if (addr == ADDR_W'(OFS_QADDR)) begin
      sel = RG_QADDR;
    end else if (addr == ADDR_W'(OFS_QSIZE)) begin
      sel = RG_QSIZE;  need = SZ_2;
    end else if (addr == ADDR_W'(OFS_QSEL)) begin
      sel = RG_QSEL;   need = SZ_2;
    end else if (addr == ADDR_W'(OFS_QNOTIFY)) begin
      sel = RG_QNOTIFY; need = SZ_2;
    end else if (addr == ADDR_W'(OFS_STATUS)) begin
      sel = RG_STATUS; need = SZ_1;
    end else if (addr == ADDR_W'(OFS_ISR)) begin
      sel = RG_ISR;    need = SZ_1;
    end
    err = (size_e'(size) == SZ_BAD)
       || (!is_cfg && (sel == RG_NONE || size_e'(size) != need))
       || (write && sel == RG_QSIZE);
  end
endmodule

// File: rtl/pvdev_isr.sv
module pvdev_isr (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic rd_clear,
  input  logic soft_clear,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= kick | (pending & ~rd_clear & ~soft_clear);
  end

  p_kick_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> pending);
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !kick) |=> !pending);
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clear && !kick) |=> !pending);
endmodule

// File: rtl/pvdev_regfront.sv
module pvdev_regfront
  import pvdev_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CFG_BASE = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [1:0]        cfg_size,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata,
  output logic [15:0]       qsz_sel,
  input  logic [15:0]       qsz_value,
  input  logic [31:0]       host_features,
  input  logic              kick,
  output logic              irq,
  output logic              notify_valid,
  output logic [15:0]       notify_idx,
  output logic [31:0]       guest_features,
  output logic [31:0]       queue_addr,
  output logic [7:0]        dev_status,
  output logic              warn
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);

  reg_e        sel;
  logic        is_cfg, dec_err;
  logic        acc, wr, rd, soft_clr, rd_isr, pending;
  logic [15:0] qsel_q, qnotify_q;
  logic [31:0] rd_mux;

  pvdev_decode #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) u_dec (
    .addr(req_addr), .size(req_size), .write(req_write),
    .sel(sel), .is_cfg(is_cfg), .err(dec_err)
  );

  assign acc      = req_valid && !dec_err;
  assign wr       = acc && req_write;
  assign rd       = acc && !req_write;
  assign soft_clr = wr && sel == RG_STATUS && req_wdata[7:0] == 8'h00;
  assign rd_isr   = rd && sel == RG_ISR;

  pvdev_isr u_isr (
    .clk(clk), .rst_n(rst_n), .kick(kick),
    .rd_clear(rd_isr), .soft_clear(soft_clr), .pending(pending)
  );
  assign irq = pending;

  // configuration pass-through
  assign cfg_valid = req_valid && is_cfg && !dec_err;
  assign cfg_write = req_write;
  assign cfg_addr  = req_addr - BASE_A;
  assign cfg_size  = req_size;
  assign cfg_wdata = req_wdata;

  assign qsz_sel = qsel_q;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      RG_HOSTF:   rd_mux = host_features;
      RG_GUESTF:  rd_mux = guest_features;
      RG_QADDR:   rd_mux = queue_addr;
      RG_QSIZE:   rd_mux = {16'h0, qsz_value};
      RG_QSEL:    rd_mux = {16'h0, qsel_q};
      RG_QNOTIFY: rd_mux = {16'h0, qnotify_q};
      RG_STATUS:  rd_mux = {24'h0, dev_status};
      RG_ISR:     rd_mux = {31'h0, pending};
      RG_CFG:     rd_mux = cfg_rdata;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guest_features <= '0;
      queue_addr     <= '0;
      qsel_q         <= '0;
      qnotify_q      <= '0;
      dev_status     <= '0;
      notify_valid   <= 1'b0;
      notify_idx     <= '0;
      warn           <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      rsp_err        <= 1'b0;
    end else begin
      notify_valid <= wr && sel == RG_QNOTIFY;
      warn         <= wr && (sel == RG_HOSTF || sel == RG_ISR);
      if (wr && sel == RG_QNOTIFY) notify_idx <= req_wdata[15:0];
      if (wr && sel == RG_QADDR)   queue_addr <= req_wdata;
      if (wr && sel == RG_STATUS)  dev_status <= req_wdata[7:0];
      if (soft_clr) begin
        guest_features <= '0;
        qsel_q         <= '0;
        qnotify_q      <= '0;
      end else begin
        if (wr && sel == RG_GUESTF)  guest_features <= req_wdata;
        if (wr && sel == RG_QSEL)    qsel_q         <= req_wdata[15:0];
        if (wr && sel == RG_QNOTIFY) qnotify_q      <= req_wdata[15:0];
      end
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec_err;
      rsp_rdata <= rd ? rd_mux : 32'h0;
    end
  end

  p_notify_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(req_valid && req_write && req_addr == ADDR_W'(OFS_QNOTIFY)));
  p_cfg_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= BASE_A) |=>
      ($stable(guest_features) && $stable(queue_addr) && $stable(qsel_q) && $stable(dev_status)));
  p_err_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ($stable(guest_features) && $stable(queue_addr) && $stable(qsel_q)
                 && $stable(dev_status) && !notify_valid && rsp_rdata == 32'h0));
  p_one_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/pvdev_regfront_tb.sv
`timescale 1ns/1ps
module pvdev_regfront_tb;
  localparam int AW = 8;
  localparam logic [31:0] HOSTF = 32'hA5A5_1234;

  typedef struct packed { logic [31:0] data; logic err; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, cfg_valid, cfg_write, irq, notify_valid, warn;
  logic [31:0] rsp_rdata, cfg_wdata, cfg_rdata, guest_features, queue_addr;
  logic [AW-1:0] cfg_addr;
  logic [1:0] cfg_size;
  logic [15:0] qsz_sel, qsz_value, notify_idx;
  logic [7:0] dev_status;
  logic kick = 0;

  int n_vec = 0, n_bad = 0;
  exp_t sb[$];
  string tagq[$];

  always #2 clk = ~clk;

  assign qsz_value = 16'h0100 + qsz_sel;
  assign cfg_rdata = 32'hCF00_0000 | {24'h0, cfg_addr};

  pvdev_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .qsz_sel(qsz_sel), .qsz_value(qsz_value), .host_features(HOSTF),
    .kick(kick), .irq(irq), .notify_valid(notify_valid), .notify_idx(notify_idx),
    .guest_features(guest_features), .queue_addr(queue_addr),
    .dev_status(dev_status), .warn(warn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per response beat
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk("R11 unexpected response", 32'h1, 32'h0);
      end else begin
        exp_t e;
        string t;
        e = sb.pop_front();
        t = tagq.pop_front();
        chk({t, " data"}, rsp_rdata, e.data);
        chk({t, " err"}, {31'h0, rsp_err}, {31'h0, e.err});
      end
    end
  end

  // driver: one request for one cycle, expectation queued
  task automatic acc(input string tag, input logic w, input logic [AW-1:0] a,
                     input logic [1:0] s, input logic [31:0] d,
                     input logic [31:0] edata, input logic eerr);
    req_valid = 1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    sb.push_back('{edata, eerr});
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic pulse_kick();
    kick = 1;
    @(negedge clk);
    kick = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset irq", {31'h0, irq}, 32'h0);
    chk("R11 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R11 reset notify", {31'h0, notify_valid}, 32'h0);
    chk("R11 reset status", {24'h0, dev_status}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R1
    acc("R1 host read", 0, 8'h00, 2, 0, HOSTF, 0);
    acc("R1 host write", 1, 8'h00, 2, 32'h1111_1111, 0, 0);
    chk("R1 warn pulse", {31'h0, warn}, 32'h1);
    acc("R1 host reread", 0, 8'h00, 2, 0, HOSTF, 0);
    chk("R1 warn drop", {31'h0, warn}, 32'h0);

    // R2
    acc("R2 guest write", 1, 8'h04, 2, 32'hDEAD_BEEF, 0, 0);
    chk("R2 guest port", guest_features, 32'hDEAD_BEEF);
    acc("R2 guest read", 0, 8'h04, 2, 0, 32'hDEAD_BEEF, 0);
    acc("R2 qaddr write", 1, 8'h08, 2, 32'h1234_5678, 0, 0);
    acc("R2 qaddr read", 0, 8'h08, 2, 0, 32'h1234_5678, 0);
    chk("R2 qaddr port", queue_addr, 32'h1234_5678);

    // R3 / R9
    acc("R9 qsel bad size", 1, 8'h0E, 0, 32'h3, 0, 1);
    chk("R9 qsel kept", {16'h0, qsz_sel}, 32'h0);
    acc("R3 qsel write", 1, 8'h0E, 1, 32'h3, 0, 0);
    chk("R3 qsel port", {16'h0, qsz_sel}, 32'h3);
    acc("R3 qsel read", 0, 8'h0E, 1, 0, 32'h3, 0);
    acc("R3 qsize read", 0, 8'h0C, 1, 0, 32'h0103, 0);
    acc("R3 qsize write err", 1, 8'h0C, 1, 32'h55, 0, 1);

    // R4
    acc("R4 notify write", 1, 8'h10, 1, 32'h7, 0, 0);
    chk("R4 notify strobe", {31'h0, notify_valid}, 32'h1);
    chk("R4 notify idx", {16'h0, notify_idx}, 32'h7);
    @(negedge clk);
    chk("R4 notify one cycle", {31'h0, notify_valid}, 32'h0);
    acc("R4 notify read", 0, 8'h10, 1, 0, 32'h7, 0);

    // R5
    acc("R5 status write", 1, 8'h12, 0, 32'h0F, 0, 0);
    chk("R5 status port", {24'h0, dev_status}, 32'h0F);
    acc("R5 status read", 0, 8'h12, 0, 0, 32'h0F, 0);

    // R6 / R7
    chk("R6 irq idle", {31'h0, irq}, 32'h0);
    pulse_kick();
    chk("R7 kick raises irq", {31'h0, irq}, 32'h1);
    acc("R6 isr write ignored", 1, 8'h13, 0, 32'h0, 0, 0);
    chk("R6 isr write warn", {31'h0, warn}, 32'h1);
    chk("R6 irq kept after write", {31'h0, irq}, 32'h1);
    acc("R6 isr read set", 0, 8'h13, 0, 0, 32'h1, 0);
    chk("R6 irq cleared", {31'h0, irq}, 32'h0);
    acc("R6 isr read clear", 0, 8'h13, 0, 0, 32'h0, 0);
    pulse_kick();
    kick = 1;
    acc("R7 isr read with kick", 0, 8'h13, 0, 0, 32'h1, 0);
    kick = 0;
    chk("R7 irq kept", {31'h0, irq}, 32'h1);

    // R8
    req_valid = 1; req_write = 0; req_addr = 8'h20; req_size = 2;
    #1;
    chk("R8 cfg_valid", {31'h0, cfg_valid}, 32'h1);
    chk("R8 cfg_addr", {24'h0, cfg_addr}, 32'h0C);
    sb.push_back('{32'hCF00_000C, 1'b0}); tagq.push_back("R8 cfg read");
    @(negedge clk);
    req_valid = 0;
    req_valid = 1; req_write = 1; req_addr = 8'h14; req_size = 1; req_wdata = 32'hABCD;
    #1;
    chk("R8 cfg base addr", {24'h0, cfg_addr}, 32'h0);
    chk("R8 cfg write dir", {31'h0, cfg_write}, 32'h1);
    chk("R8 cfg wdata", cfg_wdata, 32'hABCD);
    sb.push_back('{32'h0, 1'b0}); tagq.push_back("R8 cfg write");
    @(negedge clk);
    req_valid = 0; req_write = 0;
    acc("R8 guest untouched", 0, 8'h04, 2, 0, 32'hDEAD_BEEF, 0);
    acc("R8 top offset", 0, 8'hFF, 0, 0, 32'hCF00_00EB, 0);

    // R9
    acc("R9 unmapped", 0, 8'h01, 0, 0, 0, 1);
    acc("R9 wrong size", 0, 8'h04, 1, 0, 0, 1);
    acc("R9 bad code", 0, 8'h20, 3, 0, 0, 1);
    acc("R9 bad write guest", 1, 8'h04, 1, 32'h0, 0, 1);
    acc("R9 guest kept", 0, 8'h04, 2, 0, 32'hDEAD_BEEF, 0);

    // R10
    acc("R10 status zero", 1, 8'h12, 0, 32'h0, 0, 0);
    chk("R10 irq cleared", {31'h0, irq}, 32'h0);
    acc("R10 guest cleared", 0, 8'h04, 2, 0, 32'h0, 0);
    acc("R10 qsel cleared", 0, 8'h0E, 1, 0, 32'h0, 0);
    acc("R10 notify cleared", 0, 8'h10, 1, 0, 32'h0, 0);
    acc("R10 qaddr kept", 0, 8'h08, 2, 0, 32'h1234_5678, 0);

    repeat (2) @(negedge clk);
    chk("R11 scoreboard drained", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule